// File: doc/BRIEF.md
# Serial Port Interrupt Source Selector

This block forms the interrupt request for one direction of a frame-based multichannel serial port. The port core feeds it single-cycle event pulses: a word has completed, a 16-channel block has ended, a frame sync was seen, and a frame sync arrived when none was expected. A 2-bit source-select field, held in a small register inside the block, chooses which of these four events raises the interrupt. An enable input gates the request, so that with the enable low no request is issued in any mode.

Alongside the interrupt, the block keeps two sticky status flags for software: an overrun flag, which records that a new receive word landed while the previous word was still unread in the holding registers, and a sync-error flag, which records an unexpected frame sync. Each flag has its own clear strobe. On a sync error the block also sends an abort pulse back to the core so that the word in progress is dropped and reception or transmission restarts. The parameter `IS_RX` selects the receive variant; the transmit variant has no overrun flag, and the block otherwise behaves the same for transmit events.

Top module: `sport_irq_sel`

## Requirements
- R1: With source select 2'b00 and the enable high, a word-ready pulse (`ev_ready_i`) in cycle N gives `irq_o` high in cycle N+1.
- R2: With source select 2'b01 and the enable high, an end-of-block pulse (`ev_eob_i`) in cycle N gives `irq_o` high in cycle N+1.
- R3: With source select 2'b10 and the enable high, a frame-sync pulse (`ev_fsync_i`) in cycle N gives `irq_o` high in cycle N+1.
- R4: With source select 2'b11 and the enable high, a sync-error pulse (`ev_syncerr_i`) in cycle N gives `irq_o` high in cycle N+1; in every mode, events other than the selected one leave `irq_o` low.
- R5: When `irq_en_i` is low in cycle N, `irq_o` is low in cycle N+1 whatever events occur.
- R6: `irq_o` is high for exactly the cycles following a cycle with the selected event and the enable high, so a lone event yields a one-cycle pulse.
- R7: A write (`sel_wr_i` high) loads `sel_wdata_i` into the source select, visible on `sel_o` in the next cycle and used for events from that next cycle on; the write alone raises no interrupt, and without a write `sel_o` holds its value.
- R8: A sync-error pulse in cycle N gives `abort_o` high in cycle N+1, for one cycle per pulse, in every mode and enable setting.
- R9: In the receive variant, a word-ready pulse while `hold_full_i` is high sets `ovr_flag_o` in the next cycle; the flag stays set until `ovr_clr_i`.
- R10: A sync-error pulse sets `serr_flag_o` in the next cycle; the flag stays set until `serr_clr_i`.
- R11: A clear strobe drops its flag in the next cycle, except that a set condition in the same cycle wins and the flag stays high.
- R12: While `rst_n` is low, `irq_o`, `abort_o`, both flags and the source select (2'b00) are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_wr_i | input | 1 | Write strobe for the source select |
| sel_wdata_i | input | 2 | New source select value |
| irq_en_i | input | 1 | Interrupt enable for this direction |
| ev_ready_i | input | 1 | Word completed pulse |
| ev_eob_i | input | 1 | End of 16-channel block pulse |
| ev_fsync_i | input | 1 | Frame sync detected pulse |
| ev_syncerr_i | input | 1 | Unexpected frame sync pulse |
| hold_full_i | input | 1 | Previous word still unread in the holding registers |
| ovr_clr_i | input | 1 | Clear strobe for the overrun flag |
| serr_clr_i | input | 1 | Clear strobe for the sync-error flag |
| sel_o | output | 2 | Current source select |
| irq_o | output | 1 | Interrupt request pulse |
| abort_o | output | 1 | Abort-and-restart pulse to the core |
| ovr_flag_o | output | 1 | Sticky overrun flag (receive variant only) |
| serr_flag_o | output | 1 | Sticky sync-error flag |

## Verification
The bench drives all four events together at random so that a mux picking the wrong source, or OR-ing sources, shows up as a stray or missing pulse. It writes the source select in the same cycle as an event for the old and new source, catching a design that applies the new select one cycle early or pulses on the write itself. It raises set and clear of each flag together, where a design giving the clear priority would drop a flag that must stay high, and it toggles the enable while events fire to catch an ungated request.

// File: rtl/sport_irq_pkg.sv
// Shared encodings for the serial port interrupt source selector.
// Assumes a 2-bit source select; the code values are fixed by the port protocol.
package sport_irq_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_WORD    = 2'b00,
        SRC_BLOCK   = 2'b01,
        SRC_FSYNC   = 2'b10,
        SRC_SYNCERR = 2'b11
    } irq_src_e;

    typedef struct packed {
        logic ready;
        logic eob;
        logic fsync;
        logic syncerr;
    } irq_events_t;
endpackage

// File: rtl/sport_irq_sel_reg.sv
// Holds the interrupt source select.
// Assumes writes are single-cycle strobes; a write is visible one edge later.
module sport_irq_sel_reg
    import sport_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [SEL_W-1:0] wdata_i,
    output irq_src_e        sel_o
);
    // Load the select on a write, reset to the word source.
    always_ff @(posedge clk) begin
        if (!rst_n)    sel_o <= SRC_WORD;
        else if (wr_i) sel_o <= irq_src_e'(wdata_i);
    end
endmodule

// File: rtl/sport_irq_pulse.sv
// Picks one event by the source select and registers a gated request pulse.
// Assumes events are single-cycle pulses synchronous to clk.
module sport_irq_pulse
    import sport_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  irq_src_e    sel_i,
    input  logic        en_i,
    input  irq_events_t ev_i,
    output logic        irq_o
);
    logic picked;

    // Route the event chosen by the select.
    always_comb begin
        unique case (sel_i)
            SRC_WORD:    picked = ev_i.ready;
            SRC_BLOCK:   picked = ev_i.eob;
            SRC_FSYNC:   picked = ev_i.fsync;
            SRC_SYNCERR: picked = ev_i.syncerr;
            default:     picked = 1'b0;
        endcase
    end

    // Register the enabled request as a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= en_i & picked;
    end
endmodule

// File: rtl/sport_irq_flags.sv
// Sticky status flags and the abort pulse.
// Assumes clear strobes are single-cycle; a set in the same cycle wins.
// HAS_OVR removes the overrun flag for the transmit variant.
module sport_irq_flags #(
    parameter bit HAS_OVR = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ready_i,
    input  logic hold_full_i,
    input  logic syncerr_i,
    input  logic ovr_clr_i,
    input  logic serr_clr_i,
    output logic ovr_o,
    output logic serr_o,
    output logic abort_o
);
    // Sync-error flag: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         serr_o <= 1'b0;
        else if (syncerr_i) serr_o <= 1'b1;
        else if (serr_clr_i) serr_o <= 1'b0;
    end

    // Abort pulse to the core, one cycle per sync error.
    always_ff @(posedge clk) begin
        if (!rst_n) abort_o <= 1'b0;
        else        abort_o <= syncerr_i;
    end

    generate
        if (HAS_OVR) begin : g_ovr
            // Overrun flag: word lands while holding registers are unread.
            always_ff @(posedge clk) begin
                if (!rst_n)                      ovr_o <= 1'b0;
                else if (ready_i && hold_full_i) ovr_o <= 1'b1;
                else if (ovr_clr_i)              ovr_o <= 1'b0;
            end
        end else begin : g_no_ovr
            logic unused_ok;
            assign unused_ok = &{1'b0, ready_i, hold_full_i, ovr_clr_i};
            assign ovr_o     = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/sport_irq_sel.sv
// Top of the interrupt source selector for one port direction.
// Assumes all inputs are synchronous to clk; IS_RX picks the receive variant.
module sport_irq_sel
    import sport_irq_pkg::*;
#(
    parameter bit IS_RX = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr_i,
    input  logic [SEL_W-1:0] sel_wdata_i,
    input  logic             irq_en_i,
    input  logic             ev_ready_i,
    input  logic             ev_eob_i,
    input  logic             ev_fsync_i,
    input  logic             ev_syncerr_i,
    input  logic             hold_full_i,
    input  logic             ovr_clr_i,
    input  logic             serr_clr_i,
    output logic [SEL_W-1:0] sel_o,
    output logic             irq_o,
    output logic             abort_o,
    output logic             ovr_flag_o,
    output logic             serr_flag_o
);
    irq_src_e    sel_q;
    irq_events_t ev;

    assign ev    = '{ready: ev_ready_i, eob: ev_eob_i, fsync: ev_fsync_i, syncerr: ev_syncerr_i};
    assign sel_o = sel_q;

    sport_irq_sel_reg u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (sel_wr_i),
        .wdata_i (sel_wdata_i),
        .sel_o   (sel_q)
    );

    sport_irq_pulse u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_i (sel_q),
        .en_i  (irq_en_i),
        .ev_i  (ev),
        .irq_o (irq_o)
    );

    sport_irq_flags #(.HAS_OVR(IS_RX)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready_i     (ev_ready_i),
        .hold_full_i (hold_full_i),
        .syncerr_i   (ev_syncerr_i),
        .ovr_clr_i   (ovr_clr_i),
        .serr_clr_i  (serr_clr_i),
        .ovr_o       (ovr_flag_o),
        .serr_o      (serr_flag_o),
        .abort_o     (abort_o)
    );
endmodule

// File: rtl/sport_irq_sel_chk.sv
// Protocol checks for sport_irq_sel, bound to every instance.
// Assumes only the ports of the top module.
module sport_irq_sel_chk #(
    parameter bit IS_RX = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_wr_i,
    input logic       irq_en_i,
    input logic       ev_ready_i,
    input logic       ev_eob_i,
    input logic       ev_fsync_i,
    input logic       ev_syncerr_i,
    input logic       hold_full_i,
    input logic       ovr_clr_i,
    input logic       serr_clr_i,
    input logic [1:0] sel_o,
    input logic       irq_o,
    input logic       abort_o,
    input logic       ovr_flag_o,
    input logic       serr_flag_o
);
    AST_WORD_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o == 2'b00 && irq_en_i && ev_ready_i) |=> irq_o); // R1
    AST_BLOCK_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o == 2'b01 && irq_en_i && ev_eob_i) |=> irq_o); // R2
    AST_FSYNC_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o == 2'b10 && irq_en_i && ev_fsync_i) |=> irq_o); // R3
    AST_SYNCERR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o == 2'b11 && irq_en_i && ev_syncerr_i) |=> irq_o); // R4
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |=> !irq_o); // R5
    AST_NO_QUIET_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_ready_i || ev_eob_i || ev_fsync_i || ev_syncerr_i) |=> !irq_o); // R6
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wr_i |=> $stable(sel_o)); // R7
    AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_syncerr_i |=> abort_o); // R8
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_syncerr_i |=> !abort_o); // R8
    AST_SERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ev_syncerr_i |=> serr_flag_o); // R10
    AST_SERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (serr_flag_o && !serr_clr_i) |=> serr_flag_o); // R11

    generate
        if (IS_RX) begin : g_ovr_chk
            AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
                (ev_ready_i && hold_full_i) |=> ovr_flag_o); // R9
            AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (ovr_flag_o && !ovr_clr_i) |=> ovr_flag_o); // R11
        end else begin : g_ovr_none
            AST_OVR_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
                !ovr_flag_o); // R9
        end
    endgenerate
endmodule

bind sport_irq_sel sport_irq_sel_chk #(.IS_RX(IS_RX)) u_chk (.*);

// File: tb/sport_irq_sel_tb.sv
// Self-checking bench for sport_irq_sel: random events plus directed corners.
module sport_irq_sel_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_wr_i = 0, irq_en_i = 0;
    logic [1:0] sel_wdata_i = 0;
    logic       ev_ready_i = 0, ev_eob_i = 0, ev_fsync_i = 0, ev_syncerr_i = 0;
    logic       hold_full_i = 0, ovr_clr_i = 0, serr_clr_i = 0;
    logic [1:0] sel_o;
    logic       irq_o, abort_o, ovr_flag_o, serr_flag_o;

    int checks = 0, failures = 0;
    logic [1:0] m_sel;
    logic       m_irq, m_abort, m_ovr, m_serr;
    string      irq_tag;

    always #2.5 clk = ~clk;

    sport_irq_sel #(.IS_RX(1'b1)) u_dut (.*);

    function automatic logic pick(input logic [1:0] s, input logic r, e, f, x);
        case (s)
            2'b00:   return r;
            2'b01:   return e;
            2'b10:   return f;
            default: return x;
        endcase
    endfunction

    function automatic string tag_for(input logic [1:0] s, input logic en);
        if (!en) return "R5";
        case (s)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    // Advance one clock: update the model from the inputs, then compare.
    task automatic step();
        @(posedge clk);
        irq_tag = tag_for(m_sel, irq_en_i);
        m_irq   = irq_en_i & pick(m_sel, ev_ready_i, ev_eob_i, ev_fsync_i, ev_syncerr_i);
        m_abort = ev_syncerr_i;
        if (ev_ready_i && hold_full_i) m_ovr = 1'b1; else if (ovr_clr_i) m_ovr = 1'b0;
        if (ev_syncerr_i) m_serr = 1'b1; else if (serr_clr_i) m_serr = 1'b0;
        if (sel_wr_i) m_sel = sel_wdata_i;
        @(negedge clk);
        chk(irq_o, m_irq, irq_tag);
        chk(irq_o, m_irq, "R6");
        checks++;
        if (sel_o !== m_sel) begin
            failures++;
            $display("FAIL R7 actual=%0d expected=%0d", sel_o, m_sel);
        end
        chk(abort_o, m_abort, "R8");
        chk(ovr_flag_o, m_ovr, "R9");
        chk(serr_flag_o, m_serr, "R10");
    endtask

    task automatic idle();
        sel_wr_i = 0; ev_ready_i = 0; ev_eob_i = 0; ev_fsync_i = 0; ev_syncerr_i = 0;
        hold_full_i = 0; ovr_clr_i = 0; serr_clr_i = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5EED_1234));
        m_sel = 0; m_irq = 0; m_abort = 0; m_ovr = 0; m_serr = 0;
        // R12: reset values with events active
        ev_ready_i = 1; ev_syncerr_i = 1; hold_full_i = 1; irq_en_i = 1;
        sel_wr_i = 1; sel_wdata_i = 2'b11;
        repeat (3) @(negedge clk);
        chk(irq_o, 1'b0, "R12");
        chk(abort_o, 1'b0, "R12");
        chk(ovr_flag_o, 1'b0, "R12");
        chk(serr_flag_o, 1'b0, "R12");
        chk(sel_o == 2'b00, 1'b1, "R12");
        idle();
        rst_n = 1;
        step();

        // R7: write to fsync source with a word event same cycle -> old select fires
        irq_en_i = 1; sel_wr_i = 1; sel_wdata_i = 2'b10; ev_ready_i = 1;
        step();
        chk(irq_o, 1'b1, "R7");
        idle(); sel_wr_i = 1; sel_wdata_i = 2'b01;   // write alone, no events
        step();
        chk(irq_o, 1'b0, "R7");
        idle(); ev_eob_i = 1;                         // new select now in use
        step();
        chk(irq_o, 1'b1, "R2");

        // R11: set and clear together keep flags high
        idle(); ev_syncerr_i = 1; ev_ready_i = 1; hold_full_i = 1;
        step();
        idle(); ev_syncerr_i = 1; serr_clr_i = 1; ev_ready_i = 1; hold_full_i = 1; ovr_clr_i = 1;
        step();
        chk(serr_flag_o, 1'b1, "R11");
        chk(ovr_flag_o, 1'b1, "R11");
        idle(); serr_clr_i = 1; ovr_clr_i = 1;
        step();
        chk(serr_flag_o, 1'b0, "R11");
        chk(ovr_flag_o, 1'b0, "R11");
        idle(); ev_ready_i = 1;                       // word with holding empty: no overrun
        step();
        chk(ovr_flag_o, 1'b0, "R9");

        // Random phase over all modes and enable settings
        for (int i = 0; i < 4000; i++) begin
            idle();
            irq_en_i     = ($urandom_range(0, 3) != 0);
            ev_ready_i   = $urandom_range(0, 1);
            ev_eob_i     = ($urandom_range(0, 3) == 0);
            ev_fsync_i   = ($urandom_range(0, 2) == 0);
            ev_syncerr_i = ($urandom_range(0, 7) == 0);
            hold_full_i  = $urandom_range(0, 1);
            ovr_clr_i    = ($urandom_range(0, 5) == 0);
            serr_clr_i   = ($urandom_range(0, 5) == 0);
            sel_wr_i     = ($urandom_range(0, 15) == 0);
            sel_wdata_i  = 2'($urandom_range(0, 3));
            step();
        end

        // R4 directed: sync-error mode ignores other events
        idle(); irq_en_i = 1; sel_wr_i = 1; sel_wdata_i = 2'b11;
        step();
        idle(); ev_ready_i = 1; ev_eob_i = 1; ev_fsync_i = 1;
        step();
        chk(irq_o, 1'b0, "R4");
        idle(); ev_syncerr_i = 1;
        step();
        chk(irq_o, 1'b1, "R4");
        idle(); irq_en_i = 0; ev_syncerr_i = 1;       // R5 disabled, abort still pulses
        step();
        chk(irq_o, 1'b0, "R5");
        chk(abort_o, 1'b1, "R8");
        idle();
        step();
        chk(abort_o, 1'b0, "R8");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule